// File: doc/BRIEF.md
# Microprocessor Bus Cycle Sequencer

This block turns single transfer requests into external bus cycles for an 8-bit processor-style bus with a 16-bit address. A requester presents a cycle kind, an address and a write byte while the sequencer is idle. The sequencer then drives the address, the write data with its output enable, and four active-low strobes: memory request, I/O request, read and write. It returns the read byte together with a one-cycle completion pulse.

The clock runs at twice the T-state rate, so every T state is two clocks: a rising half (A) and a falling half (B). Memory cycles take T1, T2 and T3 and stretch by one wait state for every low sample of the active-low wait input. I/O cycles always receive one automatic wait state between T2 and T3, because the port has little time to decode its address. The wait input is sampled only at the end of that automatic wait state and at the end of any wait state after it. The write strobe is released half a T state before the address and the write data are allowed to change, which gives the target hold time.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset and whenever the sequencer is idle, `mreq_n`, `iorq_n`, `rd_n` and `wr_n` are high, `dout_oe` is low, `done` is low except in its single completion cycle, and `idle` is high.
- R2: With `wait_n` high at every sample point, a memory cycle lasts exactly 6 clocks (T1, T2, T3), and `done` is high in the clock that follows T3B.
- R3: In a memory cycle, `wait_n` is sampled at the end of T2B and at the end of each wait-state second half (TwB). Each low sample adds one wait state of 2 clocks before T3. The value of `wait_n` at any other clock has no effect.
- R4: Every I/O cycle contains one automatic wait state (2 clocks) after T2, whatever `wait_n` shows, so with no wait requested it lasts 8 clocks. `wait_n` is sampled at the end of each wait-state second half, and each low sample adds another 2 clocks.
- R5: `req_kind` encodes bit 1 = I/O (1) or memory (0) and bit 0 = write (1) or read (0). `mreq_n` is low from T1B through T3A on memory cycles only. `iorq_n` is low from T2A through T3A on I/O cycles only. The two are never low together.
- R6: On reads, `rd_n` is low from T1B (memory) or T2A (I/O) through T3A, and it is never low on writes.
- R7: On writes, `wr_n` is low from T2A through T3A. It rises at the start of T3B, while the address and the write data are still being driven. It is never low on reads.
- R8: `addr` equals the request address from T1A through T3B. On writes, `dout_oe` is high and `dout` equals the request byte from T1B through T3B.
- R9: On reads, the byte on `din` at the clock edge that ends T3A is captured. It appears on `rdata` in the cycle where `done` pulses. `done` is a single-clock pulse for every cycle kind.
- R10: A request is accepted only while `idle` is high. `req_valid` raised while a cycle is in progress changes neither the address, the kind nor the timing of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | Bit 1 = I/O, bit 0 = write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| idle | output | 1 | Sequencer can accept a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read byte |
| addr | output | 16 | Address bus |
| dout | output | 8 | Write data bus |
| dout_oe | output | 1 | Write data output enable |
| din | input | 8 | Read data bus |
| mreq_n | output | 1 | Memory request strobe, active low |
| iorq_n | output | 1 | I/O request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wait_n | input | 1 | Wait request, active low |

## Verification
The assertions assume that the requester never expects `req_valid` to be taken while `idle` is low, and that `wait_n` and `din` are settled before the edge that samples them. The bench drives every input at the falling clock edge, so every sampled input is stable. It computes the sample clocks of each cycle itself: it holds `wait_n` at the chosen value there and randomises `wait_n` at all other clocks. It places the expected read byte on `din` only during T3A and a different byte at every other clock. It also keeps `req_valid` high with different request fields during some cycles to show that these requests are ignored.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [1:0] {
      K_MEM_RD = 2'b00,
      K_MEM_WR = 2'b01,
      K_IO_RD  = 2'b10,
      K_IO_WR  = 2'b11
   } kind_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_T1A,
      S_T1B,
      S_T2A,
      S_T2B,
      S_TWA,
      S_TWB,
      S_T3A,
      S_T3B
   } slot_t;

   function automatic logic kind_is_io(kind_t k);
      return k[1];
   endfunction

   function automatic logic kind_is_wr(kind_t k);
      return k[0];
   endfunction

endpackage

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
   import bcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] kind_in,
   input  logic       wait_n,
   output slot_t      slot,
   output kind_t      kind,
   output logic       capture,
   output logic       finish
);

   slot_t slot_nx;

   // wait_n is only looked at on the last half of T2 (memory) or of a wait state
   always_comb begin
      slot_nx = slot;
      unique case (slot)
         S_IDLE:  slot_nx = start ? S_T1A : S_IDLE;
         S_T1A:   slot_nx = S_T1B;
         S_T1B:   slot_nx = S_T2A;
         S_T2A:   slot_nx = S_T2B;
         S_T2B:   slot_nx = (kind_is_io(kind) || !wait_n) ? S_TWA : S_T3A;
         S_TWA:   slot_nx = S_TWB;
         S_TWB:   slot_nx = wait_n ? S_T3A : S_TWA;
         S_T3A:   slot_nx = S_T3B;
         S_T3B:   slot_nx = S_IDLE;
         default: slot_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot <= S_IDLE;
         kind <= K_MEM_RD;
      end else begin
         slot <= slot_nx;
         if (slot == S_IDLE && start)
            kind <= kind_t'(kind_in);
      end
   end

   assign capture = (slot == S_T3A);
   assign finish  = (slot == S_T3B);

endmodule

// File: rtl/bcs_strobes.sv
module bcs_strobes
   import bcs_pkg::*;
(
   input  slot_t slot,
   input  kind_t kind,
   output logic  mreq_n,
   output logic  iorq_n,
   output logic  rd_n,
   output logic  wr_n,
   output logic  dout_oe
);

   logic win_mem;   // T1B .. T3A
   logic win_io;    // T2A .. T3A
   logic win_data;  // T1B .. T3B
   logic is_io;
   logic is_wr;

   always_comb begin
      win_mem  = slot inside {S_T1B, S_T2A, S_T2B, S_TWA, S_TWB, S_T3A};
      win_io   = slot inside {S_T2A, S_T2B, S_TWA, S_TWB, S_T3A};
      win_data = win_mem || (slot == S_T3B);
      is_io    = kind_is_io(kind);
      is_wr    = kind_is_wr(kind);
   end

   assign mreq_n  = !(!is_io && win_mem);
   assign iorq_n  = !( is_io && win_io);
   assign rd_n    = !(!is_wr && (is_io ? win_io : win_mem));
   assign wr_n    = !( is_wr && win_io);
   assign dout_oe = is_wr && win_data;

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              capture,
   input  logic              finish,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr  <= '0;
         dout  <= '0;
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         if (load) begin
            addr <= addr_in;
            dout <= wdata_in;
         end
         if (capture)
            rdata <= din;
         done <= finish;
      end
   end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              idle,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   input  logic [DATA_W-1:0] din,
   output logic              mreq_n,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   input  logic              wait_n
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("bus_cycle_seq: ADDR_W must be within 1..32");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
      $error("bus_cycle_seq: DATA_W must be within 1..64");
   end

   slot_t slot;
   kind_t kind;
   logic  start;
   logic  capture;
   logic  finish;

   assign idle  = (slot == S_IDLE);
   assign start = req_valid && idle;

   bcs_sequencer u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .kind_in (req_kind),
      .wait_n  (wait_n),
      .slot    (slot),
      .kind    (kind),
      .capture (capture),
      .finish  (finish)
   );

   bcs_strobes u_strb (
      .slot    (slot),
      .kind    (kind),
      .mreq_n  (mreq_n),
      .iorq_n  (iorq_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .dout_oe (dout_oe)
   );

   bcs_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .addr_in  (req_addr),
      .wdata_in (req_wdata),
      .capture  (capture),
      .finish   (finish),
      .din      (din),
      .addr     (addr),
      .dout     (dout),
      .rdata    (rdata),
      .done     (done)
   );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle,
   input logic              done,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe,
   input logic              mreq_n,
   input logic              iorq_n,
   input logic              rd_n,
   input logic              wr_n
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (mreq_n && iorq_n && rd_n && wr_n && !dout_oe)); // R1

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mreq_n && !iorq_n)); // R5

   AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R6

   AST_WR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> dout_oe); // R7

   AST_WR_RELEASE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (!idle && dout_oe)); // R7

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !$past(idle)) |-> $stable(addr)); // R8

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && $past(dout_oe)) |-> $stable(dout)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> idle); // R9

endmodule

bind bus_cycle_seq bcs_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .idle    (idle),
   .done    (done),
   .addr    (addr),
   .dout    (dout),
   .dout_oe (dout_oe),
   .mreq_n  (mreq_n),
   .iorq_n  (iorq_n),
   .rd_n    (rd_n),
   .wr_n    (wr_n)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        idle, done, dout_oe, mreq_n, iorq_n, rd_n, wr_n;
   logic [7:0]  rdata, dout;
   logic [15:0] addr;
   logic [7:0]  din = '0;
   logic        wait_n = 1'b1;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bus_cycle_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done),
      .rdata(rdata), .addr(addr), .dout(dout), .dout_oe(dout_oe), .din(din),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .wait_n(wait_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected cycle length in clocks, from R2/R3/R4
   function automatic int cyc_len(input logic [1:0] k, input int nw);
      return (k[1] ? 8 : 6) + 2 * nw;
   endfunction

   // first clock whose closing edge samples wait_n (R3/R4)
   function automatic int first_sample(input logic [1:0] k);
      return k[1] ? 5 : 3;
   endfunction

   function automatic string len_tag(input logic [1:0] k, input int nw);
      if (k[1]) return "R4 length";
      return (nw == 0) ? "R2 length" : "R3 length";
   endfunction

   task automatic run_txn(input logic [1:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input int nw, input bit junk);
      int   len;
      int   fs;
      logic io;
      logic wr;
      logic [7:0] rexp;
      len  = cyc_len(k, nw);
      fs   = first_sample(k);
      io   = k[1];
      wr   = k[0];
      rexp = 8'($urandom);
      @(negedge clk);
      chk("R10 idle before request", idle, 1'b1);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
      wait_n = 1'b1; din = rexp ^ 8'h5A;
      for (int s = 0; s < len; s++) begin
         @(negedge clk);
         chk(junk ? "R10 busy" : "R2 busy", idle, 1'b0);
         chk("R5 mreq_n", mreq_n, !(!io && s >= 1 && s <= len - 2));
         chk("R5 iorq_n", iorq_n, !(io && s >= 2 && s <= len - 2));
         chk("R6 rd_n", rd_n, !(!wr && s >= (io ? 2 : 1) && s <= len - 2));
         chk("R7 wr_n", wr_n, !(wr && s >= 2 && s <= len - 2));
         chk("R8 addr", addr, a);
         chk("R8 dout_oe", dout_oe, wr && s >= 1);
         if (wr && s >= 1) chk("R8 dout", dout, wd);
         chk("R9 done low while busy", done, 1'b0);
         if (junk && s < len - 1) begin
            req_valid = 1'b1; req_kind = ~k; req_addr = ~a; req_wdata = ~wd;
         end else begin
            req_valid = 1'b0;
         end
         if (s >= fs && ((s - fs) % 2 == 0))
            wait_n = (s < fs + 2 * nw) ? 1'b0 : 1'b1;
         else
            wait_n = 1'($urandom);
         din = (s == len - 2) ? rexp : (rexp ^ 8'h5A);
      end
      @(negedge clk);
      chk(len_tag(k, nw), done, 1'b1);
      chk("R1 idle after cycle", idle, 1'b1);
      chk("R1 strobes idle", {mreq_n, iorq_n, rd_n, wr_n, dout_oe}, 5'b11110);
      if (!wr) chk("R9 rdata", rdata, rexp);
      wait_n = 1'b1;
      @(negedge clk);
      chk("R9 done pulse width", done, 1'b0);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset idle", idle, 1'b1);
      chk("R1 reset done", done, 1'b0);
      chk("R1 reset strobes", {mreq_n, iorq_n, rd_n, wr_n, dout_oe}, 5'b11110);

      // directed corners
      run_txn(2'b00, 16'h1234, 8'h00, 0, 1'b0);   // R2 memory read
      run_txn(2'b01, 16'hFFFF, 8'hA5, 0, 1'b0);   // R2 R7 memory write
      run_txn(2'b10, 16'h00FE, 8'h00, 0, 1'b0);   // R4 I/O read, automatic wait only
      run_txn(2'b11, 16'h8001, 8'h3C, 0, 1'b0);   // R4 R7 I/O write
      run_txn(2'b00, 16'h0000, 8'h00, 3, 1'b0);   // R3 three waits
      run_txn(2'b11, 16'h4242, 8'hFF, 2, 1'b0);   // R4 two extra waits
      run_txn(2'b01, 16'hC0DE, 8'h81, 1, 1'b1);   // R10 request during cycle
      run_txn(2'b10, 16'h7777, 8'h00, 0, 1'b1);   // R10 request during I/O

      // constrained random
      for (int i = 0; i < 40; i++) begin
         run_txn(2'($urandom), 16'($urandom), 8'($urandom),
                 int'($urandom % 4), 1'($urandom));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule